// File: doc/BRIEF.md
# Single-Transfer DMA Channel Engine

This block is one DMA channel. It moves data between a source and a destination over a simple memory-bus master port. Before a run, software loads three 24-bit values through a small register write port: a source address, a destination address and a byte count. It then writes a configuration word whose enable bit starts the run. Each unit transfer is either one byte or one 16-bit word.

A unit can be carried out in two ways. In two-bus-cycle form the channel reads from the source and then writes the captured data to the destination. In one-bus-cycle form a single memory access is paired with an I/O strobe, so the I/O device supplies or takes the data directly. After each unit the count drops by the unit size. Each address that took part moves according to its own direction mode. When the count reaches zero, the channel disables itself and pulses a done flag.

The channel runs in one of two modes. In single mode it moves one unit per request and releases the bus between units. In burst mode one request starts back-to-back units that continue until the count is exhausted. The source side and the destination side can each add one wait cycle to their accesses.

Top module: `dma_chan`

## Requirements
- R1: After reset, `chan_en`, `done`, `bus_cyc` and `io_ack` are 0.
- R2: Register writes use `reg_sel`: 0 loads the source address, 1 the destination address, 2 the count, and 3 the configuration word. The configuration word has the following layout, with bit 0 as the enable: [11] destination no-wait, [10] source no-wait, [9] upper-lane, [8] byte unit, [7] I/O-to-memory, [6] one-bus-cycle, [5] single, [4:3] destination mode, [2:1] source mode, [0] enable. The enable takes effect only when all three 24-bit registers have been written since reset or since the last completion, and the count is nonzero. Without enable, no bus cycle occurs.
- R3: Any register write while `chan_en` is 1 is ignored.
- R4: In single mode (bit 5 = 1), each request accepted while idle and enabled performs exactly one unit. The bus then shows at least one idle cycle before the next unit. A request that arrives during a unit is ignored.
- R5: In burst mode (bit 5 = 0), one request starts units that follow each other with no idle cycle until the count reaches zero.
- R6: In two-bus-cycle mode, the unit reads at the source address (`bus_we` = 0) and then writes the captured `bus_rdata` to the destination address (`bus_we` = 1).
- R7: In one-bus-cycle mode, `io_ack` is 1 throughout the access. With bit 7 = 0 (memory to I/O), only a read at the source address occurs and the destination address is left unchanged. With bit 7 = 1 (I/O to memory), only a write at the destination address occurs and the source address is left unchanged.
- R8: Address mode 00 keeps the address fixed, 01 adds the unit size, 10 subtracts it, and 11 is treated as fixed. Address arithmetic wraps modulo 2^24.
- R9: A byte unit (bit 8 = 1) drives `bus_be` = 01, or 10 when bit 9 = 1. A word unit drives `bus_be` = 11 and moves 2 bytes.
- R10: Each side's access lasts one cycle when its no-wait bit is 1 and two cycles with the same address when it is 0. The source side uses bit 10 and the destination side uses bit 11.
- R11: After each unit the count drops by the unit size, stopping at zero. In the cycle after the last access, `done` is 1 for one cycle and `chan_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 24 | Register write data |
| req | input | 1 | Transfer request |
| bus_cyc | output | 1 | Bus access active |
| bus_we | output | 1 | Bus access is a write |
| bus_addr | output | 24 | Bus address |
| bus_be | output | 2 | Byte lane enables |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, captured on the last cycle of a read |
| io_ack | output | 1 | I/O strobe for one-bus-cycle transfers |
| done | output | 1 | One-cycle completion pulse |
| chan_en | output | 1 | Channel enabled |

## Verification
On every cycle, the assertions check the protocol rules that hold in any configuration. A bus access starts only after an accepted request on an enabled channel. The I/O strobe never appears outside an access. Lane enables are always a single lane or a full word. The done pulse lasts one cycle and coincides with the enable dropping. Only the bench scenarios can show the arithmetic: the address sequence under each direction mode and its wrap, the saturation of the count, the length of each wait, the data path from read to write, and the fact that writes made while enabled have no effect. The bench sweeps every mode combination on short counts and predicts each bus cycle.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RD_WT,
        ST_WR,
        ST_WR_WT
    } seq_st_e;

    typedef enum logic [1:0] {
        AM_FIXED = 2'b00,
        AM_INC   = 2'b01,
        AM_DEC   = 2'b10,
        AM_RSVD  = 2'b11
    } amode_e;

    // packed MSB first: configuration word bits [11:1]
    typedef struct packed {
        logic   dst_nowait;
        logic   src_nowait;
        logic   hi_lane;
        logic   unit8;
        logic   io_to_mem;
        logic   one_bus;
        logic   single;
        amode_e dst_mode;
        amode_e src_mode;
    } chan_cfg_t;

    localparam int CFG_W = $bits(chan_cfg_t);

    localparam logic [1:0] SEL_SRC = 2'd0;
    localparam logic [1:0] SEL_DST = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CFG = 2'd3;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          upd_en,
    input  logic [AW-1:0] upd_src,
    input  logic [AW-1:0] upd_dst,
    input  logic [AW-1:0] upd_cnt,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q,
    output logic [AW-1:0] cnt_q,
    output chan_cfg_t     cfg_q,
    output logic          en_q
);

    localparam int NREG = 3;

    typedef struct packed {
        logic [AW-1:0]   src;
        logic [AW-1:0]   dst;
        logic [AW-1:0]   cnt;
        chan_cfg_t       cfg;
        logic            en;
        logic [NREG-1:0] loaded;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en && !r_q.en) begin
            case (wr_sel)
                SEL_SRC: begin
                    r_d.src       = wr_data;
                    r_d.loaded[0] = 1'b1;
                end
                SEL_DST: begin
                    r_d.dst       = wr_data;
                    r_d.loaded[1] = 1'b1;
                end
                SEL_CNT: begin
                    r_d.cnt       = wr_data;
                    r_d.loaded[2] = 1'b1;
                end
                default: begin
                    r_d.cfg = chan_cfg_t'(wr_data[CFG_W:1]);
                    if (wr_data[0] && (&r_q.loaded) && (r_q.cnt != '0)) begin
                        r_d.en = 1'b1;
                    end
                end
            endcase
        end
        if (upd_en && r_q.en) begin
            r_d.src = upd_src;
            r_d.dst = upd_dst;
            r_d.cnt = upd_cnt;
            if (upd_cnt == '0) begin
                r_d.en     = 1'b0;
                r_d.loaded = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_q = r_q.src;
    assign dst_q = r_q.dst;
    assign cnt_q = r_q.cnt;
    assign cfg_q = r_q.cfg;
    assign en_q  = r_q.en;

endmodule

// File: rtl/dma_chan_step.sv
module dma_chan_step
    import dma_chan_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic [AW-1:0] addr_i,
    input  amode_e        mode_i,
    input  logic          unit8_i,
    output logic [AW-1:0] addr_o
);

    logic [AW-1:0] stride;

    always_comb begin
        stride = unit8_i ? AW'(1) : AW'(2);
        case (mode_i)
            AM_INC:  addr_o = addr_i + stride;
            AM_DEC:  addr_o = addr_i - stride;
            default: addr_o = addr_i;
        endcase
    end

endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            req_i,
    input  logic            single_i,
    input  logic            one_bus_i,
    input  logic            io_to_mem_i,
    input  logic            unit8_i,
    input  logic            hi_lane_i,
    input  logic            src_nowait_i,
    input  logic            dst_nowait_i,
    input  logic [AW-1:0]   src_i,
    input  logic [AW-1:0]   dst_i,
    input  logic [AW-1:0]   cnt_i,
    input  logic [AW-1:0]   src_nxt_i,
    input  logic [AW-1:0]   dst_nxt_i,
    input  logic [DW-1:0]   rdata_i,
    output logic            bus_cyc_o,
    output logic            bus_we_o,
    output logic [AW-1:0]   bus_addr_o,
    output logic [DW/8-1:0] bus_be_o,
    output logic [DW-1:0]   bus_wdata_o,
    output logic            io_ack_o,
    output logic            upd_en_o,
    output logic [AW-1:0]   upd_src_o,
    output logic [AW-1:0]   upd_dst_o,
    output logic [AW-1:0]   upd_cnt_o,
    output logic            done_o
);

    localparam int BE_W = DW / 8;

    typedef struct packed {
        seq_st_e       st;
        logic [DW-1:0] data;
        logic          done;
    } seq_t;

    seq_t s_d, s_q;

    logic          src_used, dst_used;
    logic          rd_last, wr_last, unit_end;
    logic [AW-1:0] bytes, cnt_nxt;
    seq_st_e       first_st;

    always_comb begin
        src_used = !(one_bus_i && io_to_mem_i);
        dst_used = !(one_bus_i && !io_to_mem_i);
        first_st = src_used ? ST_RD : ST_WR;
        bytes    = unit8_i ? AW'(1) : AW'(2);
        cnt_nxt  = (cnt_i > bytes) ? (cnt_i - bytes) : '0;
        rd_last  = (s_q.st == ST_RD && src_nowait_i) || (s_q.st == ST_RD_WT);
        wr_last  = (s_q.st == ST_WR && dst_nowait_i) || (s_q.st == ST_WR_WT);
        unit_end = wr_last || (rd_last && !dst_used);
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE:  if (en_i && req_i) s_d.st = first_st;
            ST_RD:    s_d.st = src_nowait_i ? (dst_used ? ST_WR : ST_IDLE) : ST_RD_WT;
            ST_RD_WT: s_d.st = dst_used ? ST_WR : ST_IDLE;
            ST_WR:    s_d.st = dst_nowait_i ? ST_IDLE : ST_WR_WT;
            default:  s_d.st = ST_IDLE;
        endcase
        if (rd_last) begin
            s_d.data = rdata_i;
        end
        if (unit_end) begin
            if (cnt_nxt == '0) begin
                s_d.done = 1'b1;
                s_d.st   = ST_IDLE;
            end else if (!single_i) begin
                s_d.st = first_st;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, data: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        bus_cyc_o   = (s_q.st != ST_IDLE);
        bus_we_o    = (s_q.st == ST_WR) || (s_q.st == ST_WR_WT);
        bus_addr_o  = bus_we_o ? dst_i : src_i;
        bus_wdata_o = one_bus_i ? '0 : s_q.data;
        io_ack_o    = one_bus_i && bus_cyc_o;
        if (!unit8_i) begin
            bus_be_o = '1;
        end else if (hi_lane_i) begin
            bus_be_o = BE_W'(1) << (BE_W - 1);
        end else begin
            bus_be_o = BE_W'(1);
        end
    end

    assign upd_en_o  = unit_end;
    assign upd_src_o = src_used ? src_nxt_i : src_i;
    assign upd_dst_o = dst_used ? dst_nxt_i : dst_i;
    assign upd_cnt_o = cnt_nxt;
    assign done_o    = s_q.done;

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 24,
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_sel,
    input  logic [AW-1:0]   reg_wdata,
    input  logic            req,
    output logic            bus_cyc,
    output logic            bus_we,
    output logic [AW-1:0]   bus_addr,
    output logic [DW/8-1:0] bus_be,
    output logic [DW-1:0]   bus_wdata,
    input  logic [DW-1:0]   bus_rdata,
    output logic            io_ack,
    output logic            done,
    output logic            chan_en
);

    localparam int NSIDE = 2;

    logic [AW-1:0] src_q, dst_q, cnt_q;
    chan_cfg_t     cfg_q;
    logic          upd_en;
    logic [AW-1:0] upd_src, upd_dst, upd_cnt;
    logic [AW-1:0] side_cur [NSIDE];
    logic [AW-1:0] side_nxt [NSIDE];
    amode_e        side_mode [NSIDE];

    dma_chan_regs #(.AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_sel  (reg_sel),
        .wr_data (reg_wdata),
        .upd_en  (upd_en),
        .upd_src (upd_src),
        .upd_dst (upd_dst),
        .upd_cnt (upd_cnt),
        .src_q   (src_q),
        .dst_q   (dst_q),
        .cnt_q   (cnt_q),
        .cfg_q   (cfg_q),
        .en_q    (chan_en)
    );

    assign side_cur[0]  = src_q;
    assign side_cur[1]  = dst_q;
    assign side_mode[0] = cfg_q.src_mode;
    assign side_mode[1] = cfg_q.dst_mode;

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        dma_chan_step #(.AW(AW)) u_step (
            .addr_i  (side_cur[g]),
            .mode_i  (side_mode[g]),
            .unit8_i (cfg_q.unit8),
            .addr_o  (side_nxt[g])
        );
    end

    dma_chan_seq #(.AW(AW), .DW(DW)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (chan_en),
        .req_i        (req),
        .single_i     (cfg_q.single),
        .one_bus_i    (cfg_q.one_bus),
        .io_to_mem_i  (cfg_q.io_to_mem),
        .unit8_i      (cfg_q.unit8),
        .hi_lane_i    (cfg_q.hi_lane),
        .src_nowait_i (cfg_q.src_nowait),
        .dst_nowait_i (cfg_q.dst_nowait),
        .src_i        (src_q),
        .dst_i        (dst_q),
        .cnt_i        (cnt_q),
        .src_nxt_i    (side_nxt[0]),
        .dst_nxt_i    (side_nxt[1]),
        .rdata_i      (bus_rdata),
        .bus_cyc_o    (bus_cyc),
        .bus_we_o     (bus_we),
        .bus_addr_o   (bus_addr),
        .bus_be_o     (bus_be),
        .bus_wdata_o  (bus_wdata),
        .io_ack_o     (io_ack),
        .upd_en_o     (upd_en),
        .upd_src_o    (upd_src),
        .upd_dst_o    (upd_dst),
        .upd_cnt_o    (upd_cnt),
        .done_o       (done)
    );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter int BE_W = 2
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req,
    input logic            bus_cyc,
    input logic [BE_W-1:0] bus_be,
    input logic            io_ack,
    input logic            done,
    input logic            chan_en
);

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);                                                  // R11
    AST_DONE_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !chan_en);                                               // R11
    AST_BUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> chan_en);                                             // R2
    AST_START_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cyc) |-> ($past(req) && $past(chan_en)));               // R4
    AST_IOACK_IN_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |-> bus_cyc);                                              // R7
    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_cyc |-> (($countones(bus_be) == 1) || (&bus_be)));            // R9

endmodule

bind dma_chan dma_chan_chk #(.BE_W(DW/8)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .bus_cyc (bus_cyc),
    .bus_be  (bus_be),
    .io_ack  (io_ack),
    .done    (done),
    .chan_en (chan_en)
);

// File: tb/tb_dma_chan.sv
module tb_dma_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [23:0] reg_wdata = 24'd0;
    logic        req = 1'b0;
    logic        bus_cyc, bus_we, io_ack, done, chan_en;
    logic [23:0] bus_addr;
    logic [1:0]  bus_be;
    logic [15:0] bus_wdata, bus_rdata;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    assign bus_rdata = bus_addr[15:0] ^ 16'hC3A5;

    dma_chan dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .req(req), .bus_cyc(bus_cyc), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .io_ack(io_ack), .done(done), .chan_en(chan_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] sel, input logic [23:0] data);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        step();
        reg_we = 1'b0;
    endtask

    function automatic logic [23:0] adv(input logic [23:0] a, input int mode, input int b);
        if (mode == 1) return a + 24'(b);
        if (mode == 2) return a - 24'(b);
        return a;
    endfunction

    function automatic logic [15:0] pat(input logic [23:0] a);
        return a[15:0] ^ 16'hC3A5;
    endfunction

    task automatic run_cfg(input int sm, input int dm, input bit single, input bit ob,
                           input bit i2m, input bit u8, input bit hi, input bit sw,
                           input bit dw, input int count);
        logic [23:0] s, d;
        logic [1:0]  exp_be;
        int          c, b;
        bit          last, src_used, dst_used;
        s = 24'h000001; d = 24'hFFFFFE; c = count; b = u8 ? 1 : 2;
        src_used = !(ob && i2m);
        dst_used = !(ob && !i2m);
        exp_be = u8 ? (hi ? 2'b10 : 2'b01) : 2'b11;
        wr_reg(2'd0, s);
        wr_reg(2'd1, d);
        wr_reg(2'd2, 24'(count));
        wr_reg(2'd3, {12'd0, dw, sw, hi, u8, i2m, ob, single, 2'(dm), 2'(sm), 1'b1});
        chk(chan_en == 1'b1, "R2", 32'(chan_en), 32'd1);
        last = 1'b0;
        for (int u = 0; !last; u++) begin
            if (single || u == 0) begin
                req = 1'b1; step(); req = 1'b0;
            end
            if (src_used) begin
                for (int k = 0; k < (sw ? 1 : 2); k++) begin
                    chk(bus_cyc && !bus_we, "R6", {30'd0, bus_cyc, bus_we}, 32'h2);
                    chk(bus_addr == s, "R8", 32'(bus_addr), 32'(s));
                    chk(bus_be == exp_be, "R9", 32'(bus_be), 32'(exp_be));
                    chk(io_ack == ob, "R7", 32'(io_ack), 32'(ob));
                    step();
                end
            end
            if (dst_used) begin
                for (int k = 0; k < (dw ? 1 : 2); k++) begin
                    chk(bus_cyc && bus_we, "R10", {30'd0, bus_cyc, bus_we}, 32'h3);
                    chk(bus_addr == d, "R8", 32'(bus_addr), 32'(d));
                    chk(bus_be == exp_be, "R9", 32'(bus_be), 32'(exp_be));
                    chk(io_ack == ob, "R7", 32'(io_ack), 32'(ob));
                    if (!ob) chk(bus_wdata == pat(s), "R6", 32'(bus_wdata), 32'(pat(s)));
                    step();
                end
            end
            if (src_used) s = adv(s, sm, b);
            if (dst_used) d = adv(d, dm, b);
            c = (c > b) ? c - b : 0;
            last = (c == 0);
            if (!single && !last) begin
                chk(bus_cyc == 1'b1, "R5", 32'(bus_cyc), 32'd1);
            end else begin
                chk(bus_cyc == 1'b0, "R4", 32'(bus_cyc), 32'd0);
                chk(done == last, "R11", 32'(done), 32'(last));
                chk(chan_en == !last, "R11", 32'(chan_en), 32'(!last));
            end
        end
        step();
        chk(done == 1'b0, "R11", 32'(done), 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(!chan_en && !done && !bus_cyc && !io_ack, "R1",
            {28'd0, chan_en, done, bus_cyc, io_ack}, 32'd0);

        // R2 enable refused before the three registers are loaded
        wr_reg(2'd3, 24'h000C01);
        chk(chan_en == 1'b0, "R2", 32'(chan_en), 32'd0);
        req = 1'b1; step(); req = 1'b0;
        chk(bus_cyc == 1'b0, "R2", 32'(bus_cyc), 32'd0);

        // R2 enable refused with a zero count
        wr_reg(2'd0, 24'h000010);
        wr_reg(2'd1, 24'h000020);
        wr_reg(2'd2, 24'h000000);
        wr_reg(2'd3, 24'h000C01);
        chk(chan_en == 1'b0, "R2", 32'(chan_en), 32'd0);

        // R3 writes while enabled are ignored; R4 requests during a unit ignored
        wr_reg(2'd0, 24'h000100);
        wr_reg(2'd1, 24'h000200);
        wr_reg(2'd2, 24'h000002);
        // no-wait both, byte unit, single, both forward
        wr_reg(2'd3, {12'd0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 2'b01, 1'b1});
        chk(chan_en == 1'b1, "R2", 32'(chan_en), 32'd1);
        wr_reg(2'd0, 24'h000555);
        wr_reg(2'd2, 24'h000040);
        req = 1'b1; step(); req = 1'b0;
        chk(bus_addr == 24'h000100, "R3", 32'(bus_addr), 32'h100);
        step();
        chk(bus_addr == 24'h000200, "R3", 32'(bus_addr), 32'h200);
        req = 1'b1; step();
        chk(bus_cyc == 1'b0, "R4", 32'(bus_cyc), 32'd0);
        step();
        chk(bus_cyc && !bus_we && bus_addr == 24'h000101, "R3", 32'(bus_addr), 32'h101);
        step();
        chk(bus_cyc && bus_we && bus_addr == 24'h000201, "R4", 32'(bus_addr), 32'h201);
        step();
        chk(done == 1'b1 && chan_en == 1'b0, "R11", {30'd0, done, chan_en}, 32'h2);
        step();
        chk(bus_cyc == 1'b0, "R4", 32'(bus_cyc), 32'd0);
        req = 1'b0;
        step();

        // sweep of modes, sizes, waits, forms and counts
        for (int sm = 0; sm < 4; sm++)
            for (int dm = 0; dm < 4; dm++)
                for (int form = 0; form < 3; form++)
                    for (int u8 = 0; u8 < 2; u8++)
                        for (int w = 0; w < 4; w++)
                            for (int sg = 0; sg < 2; sg++)
                                for (int cn = 3; cn < 5; cn++)
                                    run_cfg(sm, dm, sg[0], form != 0, form == 2, u8[0],
                                            u8[0] & w[0], w[0], w[1], cn);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule